// File: doc/BRIEF.md
# Per-Master Access Authority Checker

This block sits after address translation and decides whether a translated access may proceed. Permissions are not kept in the page entry itself. The entry carries a 4-bit domain index, and a small bank of shared domain registers holds, for each domain and each requesting master, one bit that forbids reads and one that forbids writes. The checker looks up the indexed domain and the bit for the access's direction, then grants or refuses the access in the same cycle.

A refused access also yields a single-cycle fault pulse one clock later. The pulse carries the master number, the direction, the address and the full entry word, so that a separate fault register block can latch it and raise an interrupt. Software programs the domain bank through a plain indexed write port with combinational read-back.

Top module: `auth_checker`

## Requirements
- R1: After reset, register 0 reads 0x00000AAA and registers 1 to 7 read 0x00000000.
- R2: Register k holds domain 2k in bits 15:0 and domain 2k+1 in bits 31:16. Within a domain half, bit 2m forbids reads and bit 2m+1 forbids writes for master m. A write with `cfg_we` high stores `cfg_wdata` into register `cfg_idx`, and `cfg_rdata` always shows register `cfg_idx`.
- R3: Bits 12 to 15 and 28 to 31 of every register hold no master and always read as zero, whatever was written.
- R4: The domain index is bits 7:4 of `acc_entry`. No other entry bit affects the decision.
- R5: A valid read by master 0..5 is refused exactly when its read-forbid bit in the indexed domain is set. A valid write is refused exactly when its write-forbid bit is set. Otherwise it is granted.
- R6: A valid access from master number 6 or 7 is always refused.
- R7: While `acc_valid` is low, `acc_grant` and `acc_deny` are both low and no fault follows.
- R8: Grant and deny follow the inputs in the same cycle. A register write made in a cycle affects checks only from the next cycle on. An access in the same cycle as the write uses the old value.
- R9: One cycle after a refused access, `flt_valid` is high for one cycle with that access's master, direction, address and entry. After a cycle without a refusal, `flt_valid` is low.
- R10: After reset, domain 0 lets every master read and forbids every write, and all other domains allow everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Domain register write strobe |
| cfg_idx | input | 3 | Domain register index for write and read |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of register `cfg_idx` |
| acc_valid | input | 1 | An access is presented for checking |
| acc_master | input | 3 | Requesting master number |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_addr | input | 32 | Address of the access |
| acc_entry | input | 32 | Page entry word; bits 7:4 select the domain |
| acc_grant | output | 1 | Access allowed |
| acc_deny | output | 1 | Access refused |
| flt_valid | output | 1 | One-cycle fault pulse |
| flt_master | output | 3 | Master of the refused access |
| flt_write | output | 1 | Direction of the refused access |
| flt_addr | output | 32 | Address of the refused access |
| flt_entry | output | 32 | Entry word of the refused access |

## Verification
On every cycle, the assertions check that grant and deny never coincide and stay quiet without a valid access. They also check that out-of-range masters are refused, that unused register bits read as zero, and that every refusal is followed by exactly one fault pulse carrying the access's fields. The decision value itself depends on register contents, so only the bench's sweeps can show it. These sweeps cover every domain, master and direction under several register patterns, with the expected bit computed from the stated bit layout. The reset contents, the masking of unused bits and the one-cycle delay before a write takes effect are shown by directed scenarios.

// File: rtl/auth_chk_pkg.sv
`timescale 1ns/1ps
package auth_chk_pkg;

  localparam int REG_W  = 32;
  localparam int HALF_W = REG_W / 2;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } acc_dir_e;

  // bits of a register that carry a master's permission pair, both halves
  function automatic logic [REG_W-1:0] live_bits(input int num_masters);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < 2 * num_masters; i++) begin
      m[i]          = 1'b1;
      m[HALF_W + i] = 1'b1;
    end
    return m;
  endfunction

  // write-forbid bits of the lower (even) domain of a register
  function automatic logic [REG_W-1:0] low_write_forbid(input int num_masters);
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < num_masters; i++) begin
      m[2 * i + 1] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/auth_domain_regs.sv
`timescale 1ns/1ps
module auth_domain_regs
  import auth_chk_pkg::*;
#(
  parameter int NUM_REGS    = 8,
  parameter int NUM_MASTERS = 6,
  parameter int IDX_W       = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [REG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [REG_W-1:0] rd_data,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [REG_W-1:0] lk_word
);

  localparam logic [REG_W-1:0] LIVE_MASK = live_bits(NUM_MASTERS);
  localparam logic [REG_W-1:0] DOM0_RST  = low_write_forbid(NUM_MASTERS);

  logic [REG_W-1:0] bank [NUM_REGS];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    localparam logic [REG_W-1:0] RST_VAL = (k == 0) ? DOM0_RST : '0;
    logic             upd_en;
    logic [REG_W-1:0] word_d;
    logic [REG_W-1:0] word_q;

    always_comb begin
      upd_en = wr_en && (wr_idx == IDX_W'(k));
      word_d = upd_en ? (wr_data & LIVE_MASK) : word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= RST_VAL;
      else        word_q <= word_d;
    end

    assign bank[k] = word_q;
  end

  assign rd_data = bank[rd_idx];
  assign lk_word = bank[lk_idx];

endmodule

// File: rtl/auth_lookup.sv
`timescale 1ns/1ps
module auth_lookup
  import auth_chk_pkg::*;
#(
  parameter int NUM_MASTERS = 6,
  parameter int MST_W       = 3,
  parameter int DOM_W       = 4,
  parameter int IDX_W       = DOM_W - 1
) (
  input  logic             valid,
  input  logic [MST_W-1:0] master,
  input  logic             write,
  input  logic [DOM_W-1:0] dom,
  output logic [IDX_W-1:0] reg_idx,
  input  logic [REG_W-1:0] reg_word,
  output logic             grant,
  output logic             deny
);

  logic [HALF_W-1:0] dom_bits;
  logic [MST_W:0]    bit_pos;
  logic              in_range;
  logic              forbid;
  acc_dir_e          dir;

  always_comb begin
    reg_idx  = dom[DOM_W-1:1];
    dom_bits = dom[0] ? reg_word[REG_W-1:HALF_W] : reg_word[HALF_W-1:0];
    dir      = acc_dir_e'(write);
    bit_pos  = {master, (dir == DIR_WR)};
    in_range = (master < MST_W'(NUM_MASTERS));
    forbid   = in_range ? dom_bits[bit_pos] : 1'b1;
    deny     = valid && forbid;
    grant    = valid && !forbid;
  end

endmodule

// File: rtl/auth_fault_reg.sv
`timescale 1ns/1ps
module auth_fault_reg #(
  parameter int MST_W   = 3,
  parameter int ADDR_W  = 32,
  parameter int ENTRY_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               deny,
  input  logic [MST_W-1:0]   master,
  input  logic               write,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [ENTRY_W-1:0] entry,
  output logic               flt_valid,
  output logic [MST_W-1:0]   flt_master,
  output logic               flt_write,
  output logic [ADDR_W-1:0]  flt_addr,
  output logic [ENTRY_W-1:0] flt_entry
);

  logic               v_d;
  logic [MST_W-1:0]   m_d;
  logic               w_d;
  logic [ADDR_W-1:0]  a_d;
  logic [ENTRY_W-1:0] e_d;

  always_comb begin
    v_d = deny;
    m_d = deny ? master : flt_master;
    w_d = deny ? write  : flt_write;
    a_d = deny ? addr   : flt_addr;
    e_d = deny ? entry  : flt_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_valid  <= 1'b0;
      flt_master <= '0;
      flt_write  <= 1'b0;
      flt_addr   <= '0;
      flt_entry  <= '0;
    end else begin
      flt_valid  <= v_d;
      flt_master <= m_d;
      flt_write  <= w_d;
      flt_addr   <= a_d;
      flt_entry  <= e_d;
    end
  end

endmodule

// File: rtl/auth_checker.sv
`timescale 1ns/1ps
module auth_checker
  import auth_chk_pkg::*;
#(
  parameter int NUM_MASTERS = 6,
  parameter int MST_W       = 3,
  parameter int NUM_DOMAINS = 16,
  parameter int ADDR_W      = 32,
  parameter int ENTRY_W     = 32,
  parameter int DOM_LSB     = 4,
  localparam int NUM_REGS   = NUM_DOMAINS / 2,
  localparam int IDX_W      = $clog2(NUM_REGS),
  localparam int DOM_W      = $clog2(NUM_DOMAINS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  input  logic               acc_valid,
  input  logic [MST_W-1:0]   acc_master,
  input  logic               acc_write,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic [ENTRY_W-1:0] acc_entry,
  output logic               acc_grant,
  output logic               acc_deny,
  output logic               flt_valid,
  output logic [MST_W-1:0]   flt_master,
  output logic               flt_write,
  output logic [ADDR_W-1:0]  flt_addr,
  output logic [ENTRY_W-1:0] flt_entry
);

  logic [IDX_W-1:0] lk_idx;
  logic [REG_W-1:0] lk_word;
  logic [DOM_W-1:0] dom_sel;

  assign dom_sel = acc_entry[DOM_LSB +: DOM_W];

  auth_domain_regs #(
    .NUM_REGS   (NUM_REGS),
    .NUM_MASTERS(NUM_MASTERS),
    .IDX_W      (IDX_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_idx (cfg_idx),
    .wr_data(cfg_wdata),
    .rd_idx (cfg_idx),
    .rd_data(cfg_rdata),
    .lk_idx (lk_idx),
    .lk_word(lk_word)
  );

  auth_lookup #(
    .NUM_MASTERS(NUM_MASTERS),
    .MST_W      (MST_W),
    .DOM_W      (DOM_W),
    .IDX_W      (IDX_W)
  ) u_lookup (
    .valid   (acc_valid),
    .master  (acc_master),
    .write   (acc_write),
    .dom     (dom_sel),
    .reg_idx (lk_idx),
    .reg_word(lk_word),
    .grant   (acc_grant),
    .deny    (acc_deny)
  );

  auth_fault_reg #(
    .MST_W  (MST_W),
    .ADDR_W (ADDR_W),
    .ENTRY_W(ENTRY_W)
  ) u_fault (
    .clk       (clk),
    .rst_n     (rst_n),
    .deny      (acc_deny),
    .master    (acc_master),
    .write     (acc_write),
    .addr      (acc_addr),
    .entry     (acc_entry),
    .flt_valid (flt_valid),
    .flt_master(flt_master),
    .flt_write (flt_write),
    .flt_addr  (flt_addr),
    .flt_entry (flt_entry)
  );

endmodule

// File: rtl/auth_checker_sva.sv
`timescale 1ns/1ps
module auth_checker_sva #(
  parameter int NUM_MASTERS = 6,
  parameter int MST_W       = 3,
  parameter int IDX_W       = 3,
  parameter int ADDR_W      = 32,
  parameter int ENTRY_W     = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [IDX_W-1:0]   cfg_idx,
  input logic [31:0]        cfg_wdata,
  input logic [31:0]        cfg_rdata,
  input logic               acc_valid,
  input logic [MST_W-1:0]   acc_master,
  input logic               acc_write,
  input logic [ADDR_W-1:0]  acc_addr,
  input logic [ENTRY_W-1:0] acc_entry,
  input logic               acc_grant,
  input logic               acc_deny,
  input logic               flt_valid,
  input logic [MST_W-1:0]   flt_master,
  input logic               flt_write,
  input logic [ADDR_W-1:0]  flt_addr,
  input logic [ENTRY_W-1:0] flt_entry
);

  logic [31:0] dead_bits;
  always_comb begin
    dead_bits = '1;
    for (int i = 0; i < 2 * NUM_MASTERS; i++) begin
      dead_bits[i]      = 1'b0;
      dead_bits[16 + i] = 1'b0;
    end
  end

  AST_GRANT_DENY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_grant && acc_deny)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!acc_grant && !acc_deny)); // R7

  AST_BAD_MASTER_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && (acc_master >= MST_W'(NUM_MASTERS))) |-> acc_deny); // R6

  AST_DEAD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & dead_bits) == 32'h0); // R3

  AST_FAULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_deny |=> flt_valid); // R9

  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_deny |=> !flt_valid); // R9

  AST_FAULT_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_deny |=> (flt_master == $past(acc_master) && flt_write == $past(acc_write)
                  && flt_addr == $past(acc_addr) && flt_entry == $past(acc_entry))); // R9

endmodule

bind auth_checker auth_checker_sva #(
  .NUM_MASTERS(NUM_MASTERS),
  .MST_W      (MST_W),
  .IDX_W      (IDX_W),
  .ADDR_W     (ADDR_W),
  .ENTRY_W    (ENTRY_W)
) u_sva (.*);

// File: tb/auth_checker_tb_top.sv
`timescale 1ns/1ps
module auth_checker_tb_top;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        acc_valid;
  logic [2:0]  acc_master;
  logic        acc_write;
  logic [31:0] acc_addr;
  logic [31:0] acc_entry;
  logic        acc_grant;
  logic        acc_deny;
  logic        flt_valid;
  logic [2:0]  flt_master;
  logic        flt_write;
  logic [31:0] flt_addr;
  logic [31:0] flt_entry;

  auth_checker dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .acc_valid(acc_valid), .acc_master(acc_master), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_entry(acc_entry),
    .acc_grant(acc_grant), .acc_deny(acc_deny),
    .flt_valid(flt_valid), .flt_master(flt_master), .flt_write(flt_write),
    .flt_addr(flt_addr), .flt_entry(flt_entry)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk;
  int n_fail;
  logic [31:0] exp_reg [8];
  localparam logic [31:0] KEEP = 32'h0FFF_0FFF;

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_deny(int d, int m, bit w);
    if (m > 5) return 1'b1;
    return exp_reg[d / 2][(d % 2) * 16 + 2 * m + int'(w)];
  endfunction

  function automatic logic [31:0] mk_entry(int d, int m, bit w);
    return {20'(d * 977 + m * 31 + 5), 4'(m ^ 10), 4'(d), (w ? 4'hF : 4'h3)};
  endfunction

  task automatic wr_reg(input int k, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(k); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    exp_reg[k] = v & KEEP;
  endtask

  task automatic rd_reg(input int k, input string req);
    @(negedge clk);
    cfg_idx = 3'(k);
    #2;
    chk(cfg_rdata == exp_reg[k], req, cfg_rdata, exp_reg[k]);
  endtask

  task automatic do_acc(input int d, input int m, input bit w, input logic [31:0] ent, input string req);
    logic [31:0] adr;
    bit ed;
    adr = 32'h4000_0000 + 32'(d) * 32'h1000 + 32'(m) * 16 + 32'(w);
    ed  = exp_deny(d, m, w);
    @(negedge clk);
    acc_valid = 1'b1; acc_master = 3'(m); acc_write = w; acc_addr = adr; acc_entry = ent;
    #2;
    chk(acc_deny == ed && acc_grant == !ed, req, {acc_grant, acc_deny}, {!ed, ed});
    @(negedge clk);
    acc_valid = 1'b0;
    #2;
    chk(!acc_grant && !acc_deny, "R7 idle outputs", {acc_grant, acc_deny}, 0);
    chk(flt_valid == ed, "R9 fault pulse", flt_valid, ed);
    if (ed)
      chk(flt_master == 3'(m) && flt_write == w && flt_addr == adr && flt_entry == ent,
          "R9 fault payload", {flt_addr, flt_entry}, {adr, ent});
    @(negedge clk);
    #2;
    chk(!flt_valid, "R9 single cycle", flt_valid, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    logic [31:0] seeds [4];
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    acc_valid = 1'b0; acc_master = '0; acc_write = 1'b0; acc_addr = '0; acc_entry = '0;
    for (int k = 0; k < 8; k++) exp_reg[k] = (k == 0) ? 32'h0000_0AAA : 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(!flt_valid && !acc_grant && !acc_deny, "R1 reset outputs", flt_valid, 0);

    // R1 reset contents
    for (int k = 0; k < 8; k++) rd_reg(k, "R1 reset value");

    // R10 reset permissions
    for (int m = 0; m < 6; m++) begin
      do_acc(0, m, 1'b0, mk_entry(0, m, 1'b0), "R10 domain0 read");
      do_acc(0, m, 1'b1, mk_entry(0, m, 1'b1), "R10 domain0 write");
      do_acc(7, m, 1'b1, mk_entry(7, m, 1'b1), "R10 other domain write");
    end

    // R4: only bits 7:4 select the domain
    do_acc(0, 2, 1'b1, 32'hFFFF_FF0F, "R4 domain0 other bits set");
    do_acc(15, 2, 1'b1, 32'hFFFF_FFFF, "R4 domain15 all ones");
    do_acc(1, 3, 1'b1, 32'h0000_0010, "R4 domain1 others clear");

    // R8: write and access in the same cycle uses the old value
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd0; cfg_wdata = 32'hFFFF_FFFF;
    acc_valid = 1'b1; acc_master = 3'd0; acc_write = 1'b0; acc_addr = 32'h10; acc_entry = 32'h0;
    #2;
    chk(acc_grant && !acc_deny, "R8 same-cycle old value", {acc_grant, acc_deny}, 2'b10);
    @(negedge clk);
    cfg_we = 1'b0;
    exp_reg[0] = 32'hFFFF_FFFF & KEEP;
    #2;
    chk(acc_deny && !acc_grant, "R8 next-cycle new value", {acc_grant, acc_deny}, 2'b01);
    @(negedge clk);
    acc_valid = 1'b0;
    @(negedge clk);

    // R2 R3 R5 R6 sweeps over several register patterns
    seeds[0] = 32'hFFFF_FFFF;
    seeds[1] = 32'h0000_0000;
    seeds[2] = 32'h5A3C_96E1;
    seeds[3] = 32'hC3A5_0F69;
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 8; k++)
        wr_reg(k, (32'(k + 1) * 32'h9E37_79B9) ^ seeds[p] ^ (p[0] ? 32'h0 : 32'hF000_F000));
      for (int k = 0; k < 8; k++) rd_reg(k, "R2 R3 register readback");
      for (int d = 0; d < 16; d++)
        for (int m = 0; m < 8; m++)
          for (int w = 0; w < 2; w++)
            do_acc(d, m, w[0], mk_entry(d, m, w[0]), (m > 5) ? "R6 bad master" : "R5 decision");
    end

    report();
  end

endmodule